// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits behind a plain word-wide register interface. Software sets an output value and a per-pin direction. These two registers go straight out to the pad ring. Software also reads back the pad inputs, which are first brought into the clock domain by a two-flop synchronizer.

Every pin has its own trigger detector. The detector can watch for a low level, a high level, a rising edge or a falling edge, and a separate per-pin override makes a pin fire on any transition. Detected events set sticky flags, and software clears a flag by writing a 1 to it. A mask register selects which flags reach the two interrupt lines. One line serves the lower sixteen pins and the other serves the upper sixteen.

Reads are registered: the value for the address presented with the read strobe appears on the read-data port one cycle later and holds until the next read.

Top module: `gpio_irq_port`

## Requirements
- R1: Offsets 0x00 (output value), 0x04 (direction, 1 = output), 0x0C (lower-half trigger config), 0x10 (upper-half trigger config), 0x14 (mask) and 0x1C (any-edge select) read back the last value written. Read data appears on `bus_rdata` in the cycle after `bus_rd_en` and holds until the next read.
- R2: Offset 0x08 returns the pad inputs after two synchronizing flops, for every pin whatever its direction. Writes to 0x08 have no effect.
- R3: Pin p's trigger field is 2 bits wide at bit 2*(p mod 16). It lives in 0x0C for pins 0–15 and in 0x10 for pins 16–31.
- R4: Field code 00 is low level and 01 is high level. While the synchronized pin holds the chosen level, its flag is set on every cycle, including the cycle right after a clear.
- R5: Field code 10 is rising edge and 11 is falling edge. The flag is set when the synchronized value differs from its previous-cycle value in that direction.
- R6: A 1 in the pin's bit at 0x1C makes the pin flag on either transition, and the pin's 2-bit field is ignored.
- R7: Writing to flag register 0x18 clears each flag whose data bit is 1 and leaves flags whose bit is 0 unchanged. A flag being set in the same cycle as it is cleared stays set. No flag rises without a detected event.
- R8: `irq_lo` is a register that holds the OR of (flags AND mask) over pins 0–15, one cycle after those values. `irq_hi` does the same over pins 16–31.
- R9: After reset the output value, direction, both config registers, mask, flags and any-edge select are zero. `pad_out` and `pad_dir` carry the output-value and direction registers.
- R10: Any other address, including addresses that are not word aligned and addresses 0x20 and above, ignores writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output value to pads |
| pad_dir | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
Directed patterns cover each trigger style separately:
- A level held across a clear shows the re-set behaviour.
- Single rising and falling steps on edge-mode pins show that each pin responds to only one direction.
- A pin whose field says rising but whose any-edge bit is set shows the override.
- Writes of zeros and of single ones to the flag register tell a proper write-1-clear apart from a plain store.
- Masks placed in one half at a time show that the two interrupt lines are split correctly.

A long random phase then toggles many pins at once while the configuration, mask and clears keep changing. A behavioural model is compared against the design on every clock, which exposes ordering faults such as a clear beating a set or a stale configuration being used.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  // word index = byte address / 4
  typedef enum logic [2:0] {
    SEL_DOUT   = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_PAD    = 3'd2,
    SEL_CFG_LO = 3'd3,
    SEL_CFG_HI = 3'd4,
    SEL_MASK   = 3'd5,
    SEL_FLAG   = 3'd6,
    SEL_ANY    = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prev_o <= '0;
    end else begin
      chain[0] <= pad_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_o <= chain[STAGES-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_port_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       any_edge,
  input  logic       cur,
  input  logic       prev,
  output logic       hit
);
  always_comb begin
    if (any_edge) begin
      hit = cur ^ prev;
    end else begin
      unique case (trig_mode_e'(mode))
        TRIG_LOW:  hit = ~cur;
        TRIG_HIGH: hit = cur;
        TRIG_RISE: hit = cur & ~prev;
        TRIG_FALL: hit = ~cur & prev;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_sync,
  input  logic [NPINS-1:0]  flags,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  cfg_lo_q,
  output logic [NPINS-1:0]  cfg_hi_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  any_q,
  output logic [NPINS-1:0]  flag_clr
);
  localparam int IDX_W = ADDR_W - 2;

  logic     addr_ok;
  reg_sel_e sel;
  logic [NPINS-1:0] rd_mux;

  assign addr_ok = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] < IDX_W'(8));
  assign sel     = reg_sel_e'(bus_addr[4:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      any_q    <= '0;
    end else if (bus_wr_en && addr_ok) begin
      case (sel)
        SEL_DOUT:   dout_q   <= bus_wdata;
        SEL_DIR:    dir_q    <= bus_wdata;
        SEL_CFG_LO: cfg_lo_q <= bus_wdata;
        SEL_CFG_HI: cfg_hi_q <= bus_wdata;
        SEL_MASK:   mask_q   <= bus_wdata;
        SEL_ANY:    any_q    <= bus_wdata;
        default:    ;
      endcase
    end
  end

  assign flag_clr = (bus_wr_en && addr_ok && sel == SEL_FLAG) ? bus_wdata : '0;

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (sel)
        SEL_DOUT:   rd_mux = dout_q;
        SEL_DIR:    rd_mux = dir_q;
        SEL_PAD:    rd_mux = pad_sync;
        SEL_CFG_LO: rd_mux = cfg_lo_q;
        SEL_CFG_HI: rd_mux = cfg_hi_q;
        SEL_MASK:   rd_mux = mask_q;
        SEL_FLAG:   rd_mux = flags;
        SEL_ANY:    rd_mux = any_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  // R10: reads outside the map return zero
  a_r10_undef_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !addr_ok) |=> (bus_rdata == '0));

  // R2: the pad register cannot be written, so a read of it follows the synchronizer
  a_r2_pad_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == ADDR_W'(8)) |=> (bus_rdata == $past(pad_sync)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_dir,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] pad_sync, pad_prev;
  logic [NPINS-1:0] cfg_lo_q, cfg_hi_q, mask_q, any_q, flag_clr;
  logic [NPINS-1:0] flags, set_vec, pending;

  gpio_pad_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_in (pad_in),
    .sync_o (pad_sync),
    .prev_o (pad_prev)
  );

  gpio_reg_file #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_sync  (pad_sync),
    .flags     (flags),
    .dout_q    (pad_out),
    .dir_q     (pad_dir),
    .cfg_lo_q  (cfg_lo_q),
    .cfg_hi_q  (cfg_hi_q),
    .mask_q    (mask_q),
    .any_q     (any_q),
    .flag_clr  (flag_clr)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = cfg_lo_q[2*p +: 2];
    end else begin : g_hi
      assign mode = cfg_hi_q[2*(p-HALF) +: 2];
    end
    gpio_pin_detect u_det (
      .mode     (mode),
      .any_edge (any_q[p]),
      .cur      (pad_sync[p]),
      .prev     (pad_prev[p]),
      .hit      (set_vec[p])
    );
  end

  // a set arriving in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | set_vec;
  end

  assign pending = flags & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= |pending[HALF-1:0];
      irq_hi <= |pending[NPINS-1:HALF];
    end
  end

  // R8: each line follows its half of the masked flags one cycle later
  a_r8_irq_lo_follows: assert property (@(posedge clk) disable iff (rst)
    irq_lo == $past(|(flags[HALF-1:0] & mask_q[HALF-1:0])));
  a_r8_irq_hi_follows: assert property (@(posedge clk) disable iff (rst)
    irq_hi == $past(|(flags[NPINS-1:HALF] & mask_q[NPINS-1:HALF])));

  // R7: a cleared flag drops unless a new event arrived with the clear
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (|flag_clr) |=> ((flags & $past(flag_clr) & ~$past(set_vec)) == '0));

  // R7: no flag rises without a detected event
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_dir;
  logic        irq_lo, irq_hi;

  int n_chk = 0, n_bad = 0;
  bit finished = 0, cmp_on = 0;

  always #5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_dir(pad_dir),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural reference model
  logic [31:0] m_dout, m_dir, m_clo, m_chi, m_mask, m_flag, m_any;
  logic [31:0] m_s1, m_s2, m_prev, m_rdata;
  logic        m_irq_lo, m_irq_hi;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_dout;
      6'h04: return m_dir;
      6'h08: return m_s2;
      6'h0C: return m_clo;
      6'h10: return m_chi;
      6'h14: return m_mask;
      6'h18: return m_flag;
      6'h1C: return m_any;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dout = 0; m_dir = 0; m_clo = 0; m_chi = 0; m_mask = 0; m_flag = 0; m_any = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_rdata = 0; m_irq_lo = 0; m_irq_hi = 0;
    end else begin
      logic [31:0] hits, clr, pend;
      hits = 0;
      for (int p = 0; p < 32; p++) begin
        int md;
        md = (p < 16) ? int'((m_clo >> (2*p)) & 3) : int'((m_chi >> (2*(p-16))) & 3);
        if (m_any[p]) hits[p] = m_s2[p] != m_prev[p];
        else if (md == 0) hits[p] = !m_s2[p];
        else if (md == 1) hits[p] = m_s2[p];
        else if (md == 2) hits[p] = m_s2[p] && !m_prev[p];
        else hits[p] = !m_s2[p] && m_prev[p];
      end
      clr = (bus_wr_en && bus_addr == 6'h18) ? bus_wdata : 32'h0;
      pend = m_flag & m_mask;
      m_irq_lo = |pend[15:0];
      m_irq_hi = |pend[31:16];
      if (bus_rd_en) m_rdata = m_read(bus_addr);
      if (bus_wr_en) begin
        case (bus_addr)
          6'h00: m_dout = bus_wdata;
          6'h04: m_dir  = bus_wdata;
          6'h0C: m_clo  = bus_wdata;
          6'h10: m_chi  = bus_wdata;
          6'h14: m_mask = bus_wdata;
          6'h1C: m_any  = bus_wdata;
          default: ;
        endcase
      end
      m_flag = (m_flag & ~clr) | hits;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R1 rdata per-cycle", bus_rdata, m_rdata);
      chk("R8 irq_lo per-cycle", {31'h0, irq_lo}, {31'h0, m_irq_lo});
      chk("R8 irq_hi per-cycle", {31'h0, irq_hi}, {31'h0, m_irq_hi});
      chk("R9 pad_out per-cycle", pad_out, m_dout);
      chk("R9 pad_dir per-cycle", pad_dir, m_dir);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    @(posedge clk);
    cmp_on = 1;

    // R9: reset state
    chk("R9 irq_lo after reset", {31'h0, irq_lo}, 32'h0);
    chk("R9 pad_out after reset", pad_out, 32'h0);
    rd(6'h14, v); chk("R9 mask reset", v, 32'h0);
    rd(6'h1C, v); chk("R9 any-edge reset", v, 32'h0);
    rd(6'h04, v); chk("R9 direction reset", v, 32'h0);
    // R4: default low-level mode with low pads flags every pin
    rd(6'h18, v); chk("R4 low level flags at default config", v, 32'hFFFF_FFFF);

    // R1: read back
    wr(6'h00, 32'hDEAD_BEEF); rd(6'h00, v); chk("R1 output value", v, 32'hDEAD_BEEF);
    chk("R9 pad_out drives value", pad_out, 32'hDEAD_BEEF);
    wr(6'h04, 32'h0F0F_00FF); rd(6'h04, v); chk("R1 direction", v, 32'h0F0F_00FF);
    wr(6'h14, 32'h1234_5678); rd(6'h14, v); chk("R1 mask", v, 32'h1234_5678);
    wr(6'h14, 32'h0);

    // R3 configuration: pins 0-15 high level, 16-30 rising, 31 falling, 30 any-edge
    wr(6'h0C, 32'h5555_5555);
    wr(6'h10, 32'hEAAA_AAAA);
    wr(6'h1C, 32'h4000_0000);
    rd(6'h10, v); chk("R1 upper config", v, 32'hEAAA_AAAA);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R7 clear all with quiet pads", v, 32'h0);

    set_pad(32'h0000_0020); idle(4);
    rd(6'h18, v); chk("R4 high level on pin 5", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); chk("R4 level re-sets after clear", v, 32'h0000_0020);
    set_pad(32'h0); idle(3);
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); chk("R7 clear sticks once level gone", v, 32'h0);

    set_pad(32'h0010_0000); idle(4);
    rd(6'h18, v); chk("R5 R3 rising on pin 20 via upper config", v, 32'h0010_0000);
    set_pad(32'h8010_0000); idle(4);
    rd(6'h18, v); chk("R5 rising ignored on falling pin 31", v, 32'h0010_0000);
    set_pad(32'h0010_0000); idle(4);
    rd(6'h18, v); chk("R5 falling on pin 31", v, 32'h8010_0000);

    set_pad(32'h4010_0000); idle(4);
    rd(6'h18, v); chk("R6 any-edge rise on pin 30", v, 32'hC010_0000);
    wr(6'h18, 32'h4000_0000);
    set_pad(32'h0010_0000); idle(4);
    rd(6'h18, v); chk("R6 any-edge fall overrides rising field", v, 32'hC010_0000);

    wr(6'h18, 32'h0);
    rd(6'h18, v); chk("R7 zero write keeps flags", v, 32'hC010_0000);

    // R8: interrupt split by half
    wr(6'h14, 32'h0010_0000); idle(2);
    chk("R8 irq_hi from pin 20", {31'h0, irq_hi}, 32'h1);
    chk("R8 irq_lo quiet", {31'h0, irq_lo}, 32'h0);
    wr(6'h18, 32'h0010_0000); idle(2);
    chk("R8 R7 irq_hi drops after clear", {31'h0, irq_hi}, 32'h0);
    wr(6'h14, 32'h0010_0020);
    set_pad(32'h0010_0020); idle(5);
    chk("R8 irq_lo from level pin 5", {31'h0, irq_lo}, 32'h1);
    chk("R8 irq_hi stays low", {31'h0, irq_hi}, 32'h0);

    // R2: pad readback regardless of direction, write ignored
    wr(6'h04, 32'hFFFF_FFFF);
    set_pad(32'hA5A5_0F0F); idle(3);
    rd(6'h08, v); chk("R2 pad readback with all outputs", v, 32'hA5A5_0F0F);
    wr(6'h08, 32'h0);
    rd(6'h08, v); chk("R2 pad write ignored", v, 32'hA5A5_0F0F);

    // R10: undefined addresses
    wr(6'h20, 32'h1234_5678);
    rd(6'h20, v); chk("R10 read above map", v, 32'h0);
    wr(6'h02, 32'hFFFF_FFFF);
    rd(6'h03, v); chk("R10 unaligned read", v, 32'h0);
    rd(6'h00, v); chk("R10 unaligned write left output value", v, 32'hDEAD_BEEF);

    // random phase, checked per clock against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 7);
      case (r)
        0: set_pad(pad_in ^ $urandom);
        1: wr(6'h0C, $urandom);
        2: wr(6'h10, $urandom);
        3: wr(6'h1C, $urandom);
        4: wr(6'h14, $urandom);
        5: wr(6'h18, $urandom);
        default: rd(6'($urandom % 64), v);
      endcase
    end
    idle(4);

    finished = 1;
    summary();
    $finish;
  end
endmodule